// File: doc/BRIEF.md
# Accumulator ALU Core

This block is the execution core of a small accumulator-style 8-bit processor. It holds an accumulator, two index registers (X and Y), an 8-bit status register and a registered result output. The sequencer around it handles fetch, addressing and memory traffic. On each cycle it presents an operation class, the operand byte it has fetched or popped, and an enable. At the next clock edge the core updates its registers and flags, and the result, status, X and Y values appear on its outputs.

Each operation class writes its own set of state: which data registers change, whether the result output is driven, and which status bits move. Branches, jumps, calls, returns, stores of X or Y and stack-pointer loads have no class of their own. The sequencer issues the no-operation code for them, and any unassigned code behaves the same way. Address-mode variants of an instruction collapse onto one class: a memory form takes its input from the operand, an accumulator form from A.

Top module: `alu8_core`

## Requirements
- R1: When `clr` is high at a clock edge, A, X, Y and the result become 0x00 and status becomes 0x22, whatever `en` and `op_i` carry.
- R2: Registers change only at a rising edge with `en` high and `clr` low, so an operation shows on the outputs after that edge and not before it. With `en` low, result, status, X and Y hold.
- R3: AND (0x01), OR (0x02) and XOR (0x03) combine A with the operand and write A and the result. Z is set when the new value is zero and N takes its bit 7; no other flag changes. Status bits are C=0, Z=1, I=2, D=3, B=4, constant one=5, V=6, N=7.
- R4: Shifts move a zero in and put the bit shifted out into C, with Z and N following the new value. Shift-left A (0x04) and shift-right A (0x06) write A and the result. Shift-left operand (0x05) and shift-right operand (0x07) write only the result.
- R5: Rotates pass through carry: the old C enters the vacated bit and the bit shifted out becomes C, with Z and N following the new value. Rotate-left A (0x08) and rotate-right A (0x0A) write A and the result. Rotate-left operand (0x09) and rotate-right operand (0x0B) write only the result.
- R6: Increment operand (0x0C) and decrement operand (0x0D) write operand±1 (mod 256) to the result. Increment/decrement X (0x0E/0x0F) and Y (0x10/0x11) change only that register, Z and N, and leave the result as it was.
- R7: Compare with A (0x12), X (0x13) or Y (0x14) sets Z and N from register minus operand and sets C when register ≥ operand (unsigned). It leaves A, X, Y and the result unchanged.
- R8: Bit test (0x15) sets Z when (A AND operand) is zero, copies operand bit 7 into N and bit 6 into V, and leaves A and C unchanged.
- R9: Load A (0x16) and pull A (0x1E) write the operand to A and to the result. Load X (0x17), load Y (0x18) and stack-to-X (0x1D) write the operand to X or Y. A-to-X (0x19) and A-to-Y (0x1A) copy A. X-to-A (0x1B) and Y-to-A (0x1C) write A but not the result. All of these update Z and N from the moved value.
- R10: Pull status (0x1F) and return-from-interrupt (0x20) load status from the operand with bit 5 forced to one.
- R11: Store A (0x22) and push A (0x21) put the current A on the result and change no flag.
- R12: Each of these touches only its own status bit: clear C (0x24), set C (0x25), clear D (0x26), set D (0x27), clear I (0x28), set I (0x29), clear V (0x2A) and break (0x23), which sets B.
- R13: No-operation (0x00) and every code from 0x2B to 0x3F change no register.
- R14: Status bit 5 reads one in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, overrides enable |
| en | input | 1 | Execute the presented operation at this edge |
| op_i | input | OPW (6) | Operation class code |
| operand_i | input | W (8) | Operand byte from memory, stack or immediate |
| result_o | output | W (8) | Registered result byte |
| status_o | output | 8 | Registered status flags |
| x_o | output | W (8) | X index register |
| y_o | output | W (8) | Y index register |

## Verification
A stale or corrupted accumulator has no port of its own. It shows one edge after the next operation that reads A: a store or push puts it on the result, and a bit test or compare against A puts it into Z, N or C. A flag whose write mask is wrong shows on `status_o` one cycle after the opcode that misuses it. For that reason the vector walk chains operations, so that each step's outputs depend on the state the step before it left behind. A wrong carry feeding a rotate therefore shows in both the data and the flags a cycle later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int ST_C   = 0;
   localparam int ST_Z   = 1;
   localparam int ST_I   = 2;
   localparam int ST_D   = 3;
   localparam int ST_B   = 4;
   localparam int ST_ONE = 5;
   localparam int ST_V   = 6;
   localparam int ST_N   = 7;

   localparam logic [7:0] STATUS_AT_CLEAR = 8'h22;
   localparam logic [7:0] STATUS_FORCED   = 8'h20;

   typedef enum logic [5:0] {
      OP_NOP     = 6'h00, OP_AND     = 6'h01, OP_OR      = 6'h02, OP_XOR     = 6'h03,
      OP_SHL_A   = 6'h04, OP_SHL_M   = 6'h05, OP_SHR_A   = 6'h06, OP_SHR_M   = 6'h07,
      OP_ROL_A   = 6'h08, OP_ROL_M   = 6'h09, OP_ROR_A   = 6'h0A, OP_ROR_M   = 6'h0B,
      OP_INC_M   = 6'h0C, OP_DEC_M   = 6'h0D, OP_INC_X   = 6'h0E, OP_DEC_X   = 6'h0F,
      OP_INC_Y   = 6'h10, OP_DEC_Y   = 6'h11, OP_CMP_A   = 6'h12, OP_CMP_X   = 6'h13,
      OP_CMP_Y   = 6'h14, OP_BIT     = 6'h15, OP_LD_A    = 6'h16, OP_LD_X    = 6'h17,
      OP_LD_Y    = 6'h18, OP_A2X     = 6'h19, OP_A2Y     = 6'h1A, OP_X2A     = 6'h1B,
      OP_Y2A     = 6'h1C, OP_SP2X    = 6'h1D, OP_PULL_A  = 6'h1E, OP_PULL_ST = 6'h1F,
      OP_RETI    = 6'h20, OP_PUSH_A  = 6'h21, OP_STORE_A = 6'h22, OP_BREAK   = 6'h23,
      OP_CLR_C   = 6'h24, OP_SET_C   = 6'h25, OP_CLR_D   = 6'h26, OP_SET_D   = 6'h27,
      OP_CLR_I   = 6'h28, OP_SET_I   = 6'h29, OP_CLR_V   = 6'h2A
   } opc_e;

   typedef enum logic [1:0] {SRC_MEM, SRC_ACC, SRC_IDX, SRC_IDY} src_e;
   typedef enum logic [1:0] {DST_NONE, DST_ACC, DST_IDX, DST_IDY} dst_e;
   typedef enum logic [3:0] {
      FN_NONE, FN_AND, FN_OR, FN_XOR, FN_SHL, FN_SHR, FN_ROL, FN_ROR,
      FN_INC, FN_DEC, FN_PASS, FN_CMP, FN_BIT
   } fn_e;

   typedef struct packed {
      src_e       src;
      fn_e        fn;
      dst_e       dst;
      logic       wr_res;
      logic       res_acc;
      logic       upd_zn;
      logic       upd_c;
      logic       upd_nv_op;
      logic       ld_status;
      logic [7:0] set_mask;
      logic [7:0] clr_mask;
   } ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
   import alu8_pkg::*;
#(
   parameter int OPW = 6
) (
   input  logic [OPW-1:0] op_i,
   output ctl_t           ctl_o
);

   localparam int CODEW = 6;

   logic             upper_clear;
   logic [CODEW-1:0] code;

   generate
      if (OPW > CODEW) begin : g_wide
         assign upper_clear = ~|op_i[OPW-1:CODEW];
      end else begin : g_exact
         assign upper_clear = 1'b1;
      end
   endgenerate

   assign code = op_i[CODEW-1:0];

   function automatic ctl_t mk(src_e s, fn_e f, dst_e d, logic wr, logic ra,
                               logic zn, logic c);
      ctl_t k;
      k           = '0;
      k.src       = s;
      k.fn        = f;
      k.dst       = d;
      k.wr_res    = wr;
      k.res_acc   = ra;
      k.upd_zn    = zn;
      k.upd_c     = c;
      return k;
   endfunction

   function automatic ctl_t flag_op(int bitpos, logic set);
      ctl_t k;
      k = mk(SRC_MEM, FN_NONE, DST_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
      if (set) k.set_mask = 8'(1) << bitpos;
      else     k.clr_mask = 8'(1) << bitpos;
      return k;
   endfunction

   always_comb begin
      ctl_o = mk(SRC_MEM, FN_NONE, DST_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
      if (upper_clear) begin
         case (code)
            OP_AND:     ctl_o = mk(SRC_ACC, FN_AND,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b0);
            OP_OR:      ctl_o = mk(SRC_ACC, FN_OR,   DST_ACC,  1'b1, 1'b0, 1'b1, 1'b0);
            OP_XOR:     ctl_o = mk(SRC_ACC, FN_XOR,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b0);
            OP_SHL_A:   ctl_o = mk(SRC_ACC, FN_SHL,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b1);
            OP_SHL_M:   ctl_o = mk(SRC_MEM, FN_SHL,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b1);
            OP_SHR_A:   ctl_o = mk(SRC_ACC, FN_SHR,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b1);
            OP_SHR_M:   ctl_o = mk(SRC_MEM, FN_SHR,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b1);
            OP_ROL_A:   ctl_o = mk(SRC_ACC, FN_ROL,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b1);
            OP_ROL_M:   ctl_o = mk(SRC_MEM, FN_ROL,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b1);
            OP_ROR_A:   ctl_o = mk(SRC_ACC, FN_ROR,  DST_ACC,  1'b1, 1'b0, 1'b1, 1'b1);
            OP_ROR_M:   ctl_o = mk(SRC_MEM, FN_ROR,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b1);
            OP_INC_M:   ctl_o = mk(SRC_MEM, FN_INC,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b0);
            OP_DEC_M:   ctl_o = mk(SRC_MEM, FN_DEC,  DST_NONE, 1'b1, 1'b0, 1'b1, 1'b0);
            OP_INC_X:   ctl_o = mk(SRC_IDX, FN_INC,  DST_IDX,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_DEC_X:   ctl_o = mk(SRC_IDX, FN_DEC,  DST_IDX,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_INC_Y:   ctl_o = mk(SRC_IDY, FN_INC,  DST_IDY,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_DEC_Y:   ctl_o = mk(SRC_IDY, FN_DEC,  DST_IDY,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_CMP_A:   ctl_o = mk(SRC_ACC, FN_CMP,  DST_NONE, 1'b0, 1'b0, 1'b1, 1'b1);
            OP_CMP_X:   ctl_o = mk(SRC_IDX, FN_CMP,  DST_NONE, 1'b0, 1'b0, 1'b1, 1'b1);
            OP_CMP_Y:   ctl_o = mk(SRC_IDY, FN_CMP,  DST_NONE, 1'b0, 1'b0, 1'b1, 1'b1);
            OP_BIT: begin
               ctl_o           = mk(SRC_ACC, FN_BIT, DST_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
               ctl_o.upd_nv_op = 1'b1;
            end
            OP_LD_A,
            OP_PULL_A:  ctl_o = mk(SRC_MEM, FN_PASS, DST_ACC,  1'b1, 1'b0, 1'b1, 1'b0);
            OP_LD_X,
            OP_SP2X:    ctl_o = mk(SRC_MEM, FN_PASS, DST_IDX,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_LD_Y:    ctl_o = mk(SRC_MEM, FN_PASS, DST_IDY,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_A2X:     ctl_o = mk(SRC_ACC, FN_PASS, DST_IDX,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_A2Y:     ctl_o = mk(SRC_ACC, FN_PASS, DST_IDY,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_X2A:     ctl_o = mk(SRC_IDX, FN_PASS, DST_ACC,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_Y2A:     ctl_o = mk(SRC_IDY, FN_PASS, DST_ACC,  1'b0, 1'b0, 1'b1, 1'b0);
            OP_PULL_ST,
            OP_RETI: begin
               ctl_o           = mk(SRC_MEM, FN_NONE, DST_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
               ctl_o.ld_status = 1'b1;
            end
            OP_PUSH_A,
            OP_STORE_A: ctl_o = mk(SRC_ACC, FN_NONE, DST_NONE, 1'b1, 1'b1, 1'b0, 1'b0);
            OP_BREAK:   ctl_o = flag_op(ST_B, 1'b1);
            OP_CLR_C:   ctl_o = flag_op(ST_C, 1'b0);
            OP_SET_C:   ctl_o = flag_op(ST_C, 1'b1);
            OP_CLR_D:   ctl_o = flag_op(ST_D, 1'b0);
            OP_SET_D:   ctl_o = flag_op(ST_D, 1'b1);
            OP_CLR_I:   ctl_o = flag_op(ST_I, 1'b0);
            OP_SET_I:   ctl_o = flag_op(ST_I, 1'b1);
            OP_CLR_V:   ctl_o = flag_op(ST_V, 1'b0);
            default: ;
         endcase
      end
   end

   always_comb begin
      assert ((ctl_o.set_mask & ctl_o.clr_mask) == 8'h00)
         else $error("AST_MASKS_DISJOINT"); // R12
   end

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int CMP_STYLE = 0
) (
   input  fn_e          fn_i,
   input  logic [W-1:0] lhs_i,
   input  logic [W-1:0] rhs_i,
   input  logic         c_i,
   output logic [W-1:0] val_o,
   output logic         c_o
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] diff;
   logic         no_borrow;

   assign diff = lhs_i - rhs_i;

   generate
      if (CMP_STYLE == 0) begin : g_cmp_sub
         logic [W:0] wide;
         assign wide      = {1'b0, lhs_i} - {1'b0, rhs_i};
         assign no_borrow = ~wide[W];
      end else begin : g_cmp_mag
         assign no_borrow = (lhs_i >= rhs_i);
      end
   endgenerate

   always_comb begin
      val_o = lhs_i;
      c_o   = c_i;
      case (fn_i)
         FN_AND:  val_o = lhs_i & rhs_i;
         FN_OR:   val_o = lhs_i | rhs_i;
         FN_XOR:  val_o = lhs_i ^ rhs_i;
         FN_SHL: begin
            val_o = {lhs_i[W-2:0], 1'b0};
            c_o   = lhs_i[W-1];
         end
         FN_SHR: begin
            val_o = {1'b0, lhs_i[W-1:1]};
            c_o   = lhs_i[0];
         end
         FN_ROL: begin
            val_o = {lhs_i[W-2:0], c_i};
            c_o   = lhs_i[W-1];
         end
         FN_ROR: begin
            val_o = {c_i, lhs_i[W-1:1]};
            c_o   = lhs_i[0];
         end
         FN_INC:  val_o = lhs_i + ONE;
         FN_DEC:  val_o = lhs_i - ONE;
         FN_PASS: val_o = lhs_i;
         FN_CMP: begin
            val_o = diff;
            c_o   = no_borrow;
         end
         FN_BIT:  val_o = lhs_i & rhs_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  ctl_t         ctl_i,
   input  logic [7:0]   status_i,
   input  logic [W-1:0] val_i,
   input  logic         c_i,
   input  logic [W-1:0] operand_i,
   output logic [7:0]   status_o
);

   logic val_zero;
   assign val_zero = (val_i == '0);

   always_comb begin
      status_o = status_i;
      if (ctl_i.ld_status)
         status_o = operand_i[7:0] | STATUS_FORCED;
      if (ctl_i.upd_zn) begin
         status_o[ST_Z] = val_zero;
         status_o[ST_N] = val_i[W-1];
      end
      if (ctl_i.upd_nv_op) begin
         status_o[ST_Z] = val_zero;
         status_o[ST_N] = operand_i[W-1];
         status_o[ST_V] = operand_i[W-2];
      end
      if (ctl_i.upd_c)
         status_o[ST_C] = c_i;
      status_o = (status_o | ctl_i.set_mask) & ~ctl_i.clr_mask;
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int OPW       = 6,
   parameter int CMP_STYLE = 0
) (
   input  logic           clk,
   input  logic           clr,
   input  logic           en,
   input  logic [OPW-1:0] op_i,
   input  logic [W-1:0]   operand_i,
   output logic [W-1:0]   result_o,
   output logic [7:0]     status_o,
   output logic [W-1:0]   x_o,
   output logic [W-1:0]   y_o
);

   generate
      if (W < 8) begin : g_bad_width
         $error("alu8_core: W must be at least 8");
      end
      if (OPW < 6) begin : g_bad_opw
         $error("alu8_core: OPW must be at least 6");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_cmp
         $error("alu8_core: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   ctl_t         ctl;
   logic [W-1:0] acc_q, x_q, y_q, res_q;
   logic [7:0]   st_q;
   logic [W-1:0] lhs, val;
   logic         c_new;
   logic [W-1:0] acc_d, x_d, y_d, res_d;
   logic [7:0]   st_d;

   alu8_decode #(.OPW(OPW)) u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   always_comb begin
      case (ctl.src)
         SRC_ACC: lhs = acc_q;
         SRC_IDX: lhs = x_q;
         SRC_IDY: lhs = y_q;
         default: lhs = operand_i;
      endcase
   end

   alu8_unit #(.W(W), .CMP_STYLE(CMP_STYLE)) u_unit (
      .fn_i  (ctl.fn),
      .lhs_i (lhs),
      .rhs_i (operand_i),
      .c_i   (st_q[ST_C]),
      .val_o (val),
      .c_o   (c_new)
   );

   alu8_flags #(.W(W)) u_flags (
      .ctl_i     (ctl),
      .status_i  (st_q),
      .val_i     (val),
      .c_i       (c_new),
      .operand_i (operand_i),
      .status_o  (st_d)
   );

   assign acc_d = (ctl.dst == DST_ACC) ? val : acc_q;
   assign x_d   = (ctl.dst == DST_IDX) ? val : x_q;
   assign y_d   = (ctl.dst == DST_IDY) ? val : y_q;
   assign res_d = !ctl.wr_res ? res_q : (ctl.res_acc ? acc_q : val);

   always_ff @(posedge clk) begin
      if (clr) begin
         acc_q <= '0;
         x_q   <= '0;
         y_q   <= '0;
         res_q <= '0;
         st_q  <= STATUS_AT_CLEAR;
      end else if (en) begin
         acc_q <= acc_d;
         x_q   <= x_d;
         y_q   <= y_d;
         res_q <= res_d;
         st_q  <= st_d;
      end
   end

   assign result_o = res_q;
   assign status_o = st_q;
   assign x_o      = x_q;
   assign y_o      = y_q;

   logic op_cmp, op_bit, op_ldst, op_putacc, op_idxstep, op_cmpx;
   assign op_cmp     = en && (op_i == OPW'(OP_CMP_A) || op_i == OPW'(OP_CMP_X) ||
                              op_i == OPW'(OP_CMP_Y));
   assign op_cmpx    = en && (op_i == OPW'(OP_CMP_X));
   assign op_bit     = en && (op_i == OPW'(OP_BIT));
   assign op_ldst    = en && (op_i == OPW'(OP_PULL_ST) || op_i == OPW'(OP_RETI));
   assign op_putacc  = en && (op_i == OPW'(OP_STORE_A) || op_i == OPW'(OP_PUSH_A));
   assign op_idxstep = en && (op_i == OPW'(OP_INC_X) || op_i == OPW'(OP_DEC_X) ||
                              op_i == OPW'(OP_INC_Y) || op_i == OPW'(OP_DEC_Y));

   AST_CLEAR_STATE: assert property (@(posedge clk)
      clr |=> (st_q == STATUS_AT_CLEAR && x_q == '0 && y_q == '0 && res_q == '0 && acc_q == '0)); // R1
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (clr)
      !en |=> ($stable(res_q) && $stable(st_q) && $stable(x_q) && $stable(y_q))); // R2
   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (clr)
      op_cmp |=> ($stable(acc_q) && $stable(x_q) && $stable(y_q) && $stable(res_q))); // R7
   AST_CMP_CARRY: assert property (@(posedge clk) disable iff (clr)
      op_cmpx |=> (st_q[ST_C] == ($past(x_q) >= $past(operand_i)))); // R7
   AST_BIT_COPIES: assert property (@(posedge clk) disable iff (clr)
      op_bit |=> (st_q[ST_N] == $past(operand_i[W-1]) && st_q[ST_V] == $past(operand_i[W-2])
                  && $stable(acc_q))); // R8
   AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (clr)
      op_ldst |=> (st_q == ($past(operand_i[7:0]) | STATUS_FORCED))); // R10
   AST_ACC_TO_RESULT: assert property (@(posedge clk) disable iff (clr)
      op_putacc |=> (res_q == $past(acc_q) && $stable(st_q))); // R11
   AST_INDEX_KEEPS_RESULT: assert property (@(posedge clk) disable iff (clr)
      op_idxstep |=> $stable(res_q)); // R6
   AST_ONE_BIT_SET: assert property (@(posedge clk) disable iff (clr)
      st_q[ST_ONE]); // R14

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       en  = 1'b0;
   logic [5:0] op  = 6'h00;
   logic [7:0] m   = 8'h00;
   logic [7:0] result, status, xr, yr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   alu8_core uut (
      .clk       (clk),
      .clr       (clr),
      .en        (en),
      .op_i      (op),
      .operand_i (m),
      .result_o  (result),
      .status_o  (status),
      .x_o       (xr),
      .y_o       (yr)
   );

   // {req, op, operand, exp result, exp status, exp X, exp Y}
   localparam logic [55:0] VEC [0:47] = '{
      56'h09_16_81_81_A0_00_00, // R9 load A
      56'h03_01_0F_01_20_00_00, // R3 and
      56'h03_02_F0_F1_A0_00_00, // R3 or
      56'h03_03_F1_00_22_00_00, // R3 xor to zero
      56'h0C_25_00_00_23_00_00, // R12 set C
      56'h05_0A_00_80_A0_00_00, // R5 rotate right A
      56'h05_08_00_00_23_00_00, // R5 rotate left A
      56'h05_09_40_81_A0_00_00, // R5 rotate left operand
      56'h0B_22_00_00_A0_00_00, // R11 store A
      56'h04_05_C3_86_A1_00_00, // R4 shift left operand
      56'h04_07_01_00_23_00_00, // R4 shift right operand
      56'h09_16_41_41_21_00_00, // R9
      56'h04_04_00_82_A0_00_00, // R4 shift left A
      56'h04_06_00_41_20_00_00, // R4 shift right A
      56'h06_0C_FF_00_22_00_00, // R6 inc operand wrap
      56'h06_0D_00_FF_A0_00_00, // R6 dec operand wrap
      56'h06_0F_00_FF_A0_FF_00, // R6 dec X
      56'h06_0E_00_FF_22_00_00, // R6 inc X
      56'h06_10_00_FF_20_00_01, // R6 inc Y
      56'h06_11_00_FF_22_00_00, // R6 dec Y
      56'h09_17_7F_FF_20_7F_00, // R9 load X
      56'h07_13_7F_FF_23_7F_00, // R7 compare X equal
      56'h07_12_42_FF_A0_7F_00, // R7 compare A below
      56'h07_14_00_FF_23_7F_00, // R7 compare Y zero
      56'h08_15_C0_FF_E1_7F_00, // R8 bit test
      56'h08_15_3E_FF_23_7F_00, // R8 bit test zero
      56'h09_1A_00_FF_21_7F_41, // R9 A to Y
      56'h09_1B_00_FF_21_7F_41, // R9 X to A
      56'h0B_22_00_7F_21_7F_41, // R11
      56'h09_1C_00_7F_21_7F_41, // R9 Y to A
      56'h0B_21_00_41_21_7F_41, // R11 push A
      56'h09_18_00_41_23_7F_00, // R9 load Y
      56'h09_19_00_41_21_41_00, // R9 A to X
      56'h09_1D_90_41_A1_90_00, // R9 stack to X
      56'h09_1E_00_00_23_90_00, // R9 pull A
      56'h0A_1F_00_00_20_90_00, // R10 pull status
      56'h0A_20_DF_00_FF_90_00, // R10 return from interrupt
      56'h0C_24_00_00_FE_90_00, // R12 clear C
      56'h0C_26_00_00_F6_90_00, // R12 clear D
      56'h0C_28_00_00_F2_90_00, // R12 clear I
      56'h0C_2A_00_00_B2_90_00, // R12 clear V
      56'h0C_27_00_00_BA_90_00, // R12 set D
      56'h0C_29_00_00_BE_90_00, // R12 set I
      56'h0A_1F_00_00_20_90_00, // R10
      56'h0C_23_00_00_30_90_00, // R12 break
      56'h0D_00_FF_00_30_90_00, // R13 no-op
      56'h0D_3F_55_00_30_90_00, // R13 unassigned code
      56'h0B_22_00_00_30_90_00  // R11 A untouched
   };

   task automatic check(string req, logic [7:0] er, logic [7:0] es,
                        logic [7:0] ex, logic [7:0] ey);
      checks++;
      if (result !== er || status !== es || xr !== ex || yr !== ey) begin
         errors++;
         $display("FAIL %s: actual res=%h st=%h x=%h y=%h expected res=%h st=%h x=%h y=%h",
                  req, result, status, xr, yr, er, es, ex, ey);
      end
   endtask

   task automatic run_op(logic [5:0] o, logic [7:0] d);
      en = 1'b1;
      op = o;
      m  = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2: watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      clr = 1'b0;
      check("R1 reset state", 8'h00, 8'h22, 8'h00, 8'h00);

      for (int i = 0; i < 48; i++) begin
         logic [55:0] v;
         v = VEC[i];
         run_op(v[45:40], v[39:32]);
         check($sformatf("R%0d vector %0d", v[55:48], i), v[31:24], v[23:16], v[15:8], v[7:0]);
      end

      // R2: nothing moves before the edge, then the load lands
      en = 1'b1;
      op = 6'h17;
      m  = 8'h11;
      #1;
      check("R2 before edge", 8'h00, 8'h30, 8'h90, 8'h00);
      @(posedge clk);
      @(negedge clk);
      check("R2 after edge", 8'h00, 8'h30, 8'h11, 8'h00);

      // R2: enable low holds everything
      en = 1'b0;
      op = 6'h16;
      m  = 8'h00;
      repeat (3) @(negedge clk);
      check("R2 enable low", 8'h00, 8'h30, 8'h11, 8'h00);
      run_op(6'h22, 8'h00);
      check("R2 A held while idle", 8'h00, 8'h30, 8'h11, 8'h00);

      // R1: clear wins over an enabled operation
      run_op(6'h16, 8'h55);
      check("R1 setup", 8'h55, 8'h30, 8'h11, 8'h00);
      clr = 1'b1;
      run_op(6'h17, 8'h77);
      check("R1 clear over enable", 8'h00, 8'h22, 8'h00, 8'h00);
      clr = 1'b0;
      run_op(6'h22, 8'h00);
      check("R1 accumulator cleared", 8'h00, 8'h22, 8'h00, 8'h00);

      en = 1'b0;
      finish_run();
   end

endmodule